// File: doc/BRIEF.md
# Vectored Interrupt Arbiter for a Dual-Channel Serial Peripheral

This block decides which of six interrupt sources of a two-channel serial peripheral may interrupt the processor. The sources are receive, transmit and external/status events, one of each per channel. Each source carries three bits: enable, pending and under-service. A master enable gates every request. The channel logic that detects the events is outside the block. It reaches the block as one-cycle pulses.

The block joins a priority chain of peripherals. A high enable-in lets it request through an active-low request output. An enable-out passes priority on to the devices below it. In an acknowledge cycle, marked by active-low address and data strobes, the block supplies an 8-bit software-written vector and marks the winning source as under service. When the vector is read through channel B, bits 3:1 of the vector carry a code naming the source. Software ends service with a command that releases the highest-priority under-service bit. It removes each pending bit once that bit's cause has been handled.

Top module: `sio_irq_arbiter`

## Requirements
- R1: Source indices are 0 A-receive, 1 A-transmit, 2 A-external, 3 B-receive, 4 B-transmit, 5 B-external, and a lower index has higher priority. The acknowledged source is the lowest-index pending source that is not blocked.
- R2: A pending bit is never set while its enable bit in `src_en_i` is low, and it is cleared on the clock after the enable goes low.
- R3: While `mie_i` is low, `irq_n_o` stays high and no acknowledge is accepted.
- R4: `irq_n_o` is low exactly when `chain_in_i` is high, `mie_i` is high and some pending source has no under-service bit set at its own or a higher priority. While `chain_in_i` is low, no acknowledge is accepted.
- R5: While any under-service bit is set, `chain_out_o` is low and that source and all lower-priority sources cannot request. Otherwise `chain_out_o` follows `chain_in_i`.
- R6: After an interrupt pulse is sampled, the pending bit sets on the second rising edge of `as_n_i` that is sampled on a later clock. It becomes visible on `ip_o` from that clock on.
- R7: On a clock where `intack_i` is high, `ds_n_i` is first seen low and a request is active, the block sets `vec_oe_o` and the winner's under-service bit on that clock. `vec_oe_o` stays high until `ds_n_i` goes high or `intack_i` goes low.
- R8: The vector equals `vec_base_i` when `stat_via_b_i` is low. When it is high, bits 3:1 of the vector are replaced by the code: B-transmit 000, B-external 001, B-receive 010, B-special 011, and 100 to 111 for the same four kinds on channel A.
- R9: `rx_mode_i` holds 2 bits per channel, A in bits 1:0. Mode 0 interrupts only on the first character after the receive enable is set. Mode 1 interrupts on every character. Modes 2 and 3 interrupt on no character.
- R10: `rx_err_i` holds 4 bits per channel: bit 0 overrun, 1 framing, 2 end of frame, 3 parity. Parity counts only when `par_spec_i` is set for that channel. A special condition interrupts in every mode, except in mode 0 before the first character, and gives the special code.
- R11: A transmit-empty pulse raises a transmit interrupt only if a `tx_load_i` pulse has occurred since the previous transmit interrupt.
- R12: An `ius_reset_i` pulse clears only the highest-priority under-service bit that is set. An `ip_clr_i` bit clears the matching pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| intack_i | input | 1 | Acknowledge cycle in progress |
| chain_in_i | input | 1 | Priority chain enable from the device above |
| chain_out_o | output | 1 | Priority chain enable to the device below |
| irq_n_o | output | 1 | Interrupt request, active low |
| vec_oe_o | output | 1 | Vector being driven |
| vec_data_o | output | 8 | Vector value |
| mie_i | input | 1 | Master interrupt enable |
| src_en_i | input | 6 | Per-source enables |
| rx_mode_i | input | 4 | Receive interrupt mode per channel |
| par_spec_i | input | 2 | Parity counts as special, per channel |
| vec_base_i | input | 8 | Software-written vector |
| stat_via_b_i | input | 1 | Vector read through channel B (insert code) |
| rx_char_i | input | 2 | Character received pulse per channel |
| rx_err_i | input | 8 | Receive error pulses per channel |
| tx_load_i | input | 2 | Transmit buffer written pulse per channel |
| tx_empty_i | input | 2 | Transmit buffer empty pulse per channel |
| ext_evt_i | input | 2 | External/status event pulse per channel |
| ip_clr_i | input | 6 | Clear pending bit, per source |
| ius_reset_i | input | 1 | Release highest under-service bit |
| ip_o | output | 6 | Pending bits |

## Verification
The assertions take several things for granted about the inputs. `vec_base_i` does not change while a vector is driven. An acknowledge begins only with `ds_n_i` high in the cycle before it falls. The vector check relies on the first of these. The reference model tracks each pending bit with one counter, so it also assumes a source has only one event in flight: a new pulse for that source arrives only after the previous one has reached its pending bit or been cleared. The stimulus meets these assumptions by construction. It changes configuration only between acknowledge cycles, always opens the data strobe from the idle-high level, and waits two full address-strobe pulses after every event pulse.

// File: rtl/sio_irq_pkg.sv
// Shared constants and helpers for the interrupt arbiter.
// Assumes two channels of three sources each; source index = channel*3 + kind.
package sio_irq_pkg;
    localparam int NCH    = 2;
    localparam int NTYPE  = 3;
    localparam int NSRC   = NCH * NTYPE;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int ERR_W  = 4;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        RXM_FIRST    = 2'd0,
        RXM_ALL      = 2'd1,
        RXM_SPEC     = 2'd2,
        RXM_SPEC_ALT = 2'd3
    } rx_mode_e;

    // Status code for a source: MSB marks channel A, low bits give the kind.
    function automatic logic [CODE_W-1:0] src_code(input logic [SRC_W-1:0] idx,
                                                   input logic rx_spec);
        logic [1:0] kind;
        int         c;
        int         t;
        c = int'(idx) / NTYPE;
        t = int'(idx) % NTYPE;
        case (t)
            0:       kind = rx_spec ? 2'b11 : 2'b10;
            1:       kind = 2'b00;
            default: kind = 2'b01;
        endcase
        return {c == 0, kind};
    endfunction
endpackage

// File: rtl/sio_chan_cond.sv
// Turns one channel's raw event pulses into interrupt condition pulses.
// Handles the receive mode, the special-condition set and transmit arming.
// Assumes the event inputs are single-cycle pulses in the clk domain.
module sio_chan_cond
    import sio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [1:0]       rx_mode,
    input  logic             par_spec,
    input  logic             rx_char,
    input  logic [ERR_W-1:0] rx_err,
    input  logic             rx_ip_clr,
    input  logic             tx_load,
    input  logic             tx_empty,
    input  logic             ext_evt,
    output logic [NTYPE-1:0] cond_o,
    output logic             rx_spec_o
);
    logic first_seen;
    logic tx_armed;
    logic spec_q;
    logic special;
    logic char_hit;
    logic spec_hit;

    // Decide which receive events raise an interrupt under the current mode.
    always_comb begin
        special = (|rx_err[2:0]) | (rx_err[3] & par_spec);
        case (rx_mode_e'(rx_mode))
            RXM_FIRST: begin
                char_hit = rx_char & ~first_seen;
                spec_hit = special & first_seen;
            end
            RXM_ALL: begin
                char_hit = rx_char;
                spec_hit = special;
            end
            default: begin
                char_hit = 1'b0;
                spec_hit = special;
            end
        endcase
    end

    assign cond_o[0]  = rx_en & (char_hit | spec_hit);
    assign cond_o[1]  = tx_empty & tx_armed;
    assign cond_o[2]  = ext_evt;
    assign rx_spec_o  = spec_q;

    // Track first character, transmit arming and the special flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_seen <= 1'b0;
            tx_armed   <= 1'b0;
            spec_q     <= 1'b0;
        end else begin
            first_seen <= rx_en & (first_seen | rx_char);
            if (tx_load) begin
                tx_armed <= 1'b1;
            end else if (tx_empty) begin
                tx_armed <= 1'b0;
            end
            if (!rx_en) begin
                spec_q <= 1'b0;
            end else if (spec_hit) begin
                spec_q <= 1'b1;
            end else if (rx_ip_clr) begin
                spec_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_src_sync.sv
// Pending-bit stage for one source: a condition is carried across two
// address-strobe rising edges before it becomes pending.
// Assumes as_rise is a one-cycle pulse per strobe end.
module sio_src_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic as_rise,
    input  logic en,
    input  logic cond,
    input  logic clr,
    output logic ip_o
);
    logic lat;
    logic stage;

    // Advance the condition on each strobe end and hold the pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat   <= 1'b0;
            stage <= 1'b0;
            ip_o  <= 1'b0;
        end else begin
            if (!en) begin
                lat   <= 1'b0;
                stage <= 1'b0;
            end else if (as_rise) begin
                stage <= lat;
                lat   <= cond;
            end else begin
                lat <= lat | cond;
            end
            ip_o <= en & ((as_rise & stage) | (ip_o & ~clr));
        end
    end
endmodule

// File: rtl/sio_prio_arb.sv
// Fixed-priority selection among pending sources. Index 0 ranks highest.
// An under-service bit blocks its own source and all lower ones.
module sio_prio_arb #(
    parameter int N = 6
) (
    input  logic                 mie,
    input  logic                 chain_in,
    input  logic [N-1:0]         ip,
    input  logic [N-1:0]         ius,
    output logic                 req_o,
    output logic [N-1:0]         win_oh_o,
    output logic [$clog2(N)-1:0] win_idx_o
);
    localparam int IW = $clog2(N);

    logic blk;
    logic found;

    // Scan from highest priority, stopping at the first eligible source.
    always_comb begin
        blk       = 1'b0;
        found     = 1'b0;
        win_oh_o  = '0;
        win_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            blk = blk | ius[i];
            if (mie && ip[i] && !blk && !found) begin
                found       = 1'b1;
                win_oh_o[i] = 1'b1;
                win_idx_o   = IW'(i);
            end
        end
    end

    assign req_o = chain_in & found;
endmodule

// File: rtl/sio_vec_fmt.sv
// Builds the acknowledge vector, optionally placing the source code in it.
module sio_vec_fmt #(
    parameter int VEC_W    = 8,
    parameter int STAT_LSB = 1,
    parameter int CODE_W   = 3
) (
    input  logic [VEC_W-1:0]  base,
    input  logic              insert,
    input  logic [CODE_W-1:0] code,
    output logic [VEC_W-1:0]  vec_o
);
    // Overlay the code field on the software vector when requested.
    always_comb begin
        vec_o = base;
        if (insert) begin
            vec_o[STAT_LSB +: CODE_W] = code;
        end
    end
endmodule

// File: rtl/sio_irq_arbiter.sv
// Interrupt arbiter top: six sources, chain priority, vectored acknowledge.
// Assumes active-low strobes sampled in the clk domain and one-cycle event pulses.
module sio_irq_arbiter
    import sio_irq_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int STAT_LSB = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   as_n_i,
    input  logic                   ds_n_i,
    input  logic                   intack_i,
    input  logic                   chain_in_i,
    output logic                   chain_out_o,
    output logic                   irq_n_o,
    output logic                   vec_oe_o,
    output logic [VEC_W-1:0]       vec_data_o,
    input  logic                   mie_i,
    input  logic [NSRC-1:0]        src_en_i,
    input  logic [2*NCH-1:0]       rx_mode_i,
    input  logic [NCH-1:0]         par_spec_i,
    input  logic [VEC_W-1:0]       vec_base_i,
    input  logic                   stat_via_b_i,
    input  logic [NCH-1:0]         rx_char_i,
    input  logic [ERR_W*NCH-1:0]   rx_err_i,
    input  logic [NCH-1:0]         tx_load_i,
    input  logic [NCH-1:0]         tx_empty_i,
    input  logic [NCH-1:0]         ext_evt_i,
    input  logic [NSRC-1:0]        ip_clr_i,
    input  logic                   ius_reset_i,
    output logic [NSRC-1:0]        ip_o
);
    logic              as_q;
    logic              ds_q;
    logic              as_rise;
    logic              ds_fall;
    logic [NSRC-1:0]   cond;
    logic [NCH-1:0]    rx_spec;
    logic [NSRC-1:0]   ip;
    logic [NSRC-1:0]   ius_q;
    logic [NSRC-1:0]   ius_clr;
    logic [NSRC-1:0]   win_oh;
    logic [SRC_W-1:0]  win_idx;
    logic              req;
    logic              win_spec;
    logic              ack_hit;
    logic [VEC_W-1:0]  vec_next;
    logic [VEC_W-1:0]  vec_q;
    logic              oe_q;

    // Remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q <= 1'b1;
            ds_q <= 1'b1;
        end else begin
            as_q <= as_n_i;
            ds_q <= ds_n_i;
        end
    end

    assign as_rise = as_n_i & ~as_q;
    assign ds_fall = ~ds_n_i & ds_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        sio_chan_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_en     (src_en_i[ch*NTYPE]),
            .rx_mode   (rx_mode_i[2*ch +: 2]),
            .par_spec  (par_spec_i[ch]),
            .rx_char   (rx_char_i[ch]),
            .rx_err    (rx_err_i[ERR_W*ch +: ERR_W]),
            .rx_ip_clr (ip_clr_i[ch*NTYPE]),
            .tx_load   (tx_load_i[ch]),
            .tx_empty  (tx_empty_i[ch]),
            .ext_evt   (ext_evt_i[ch]),
            .cond_o    (cond[ch*NTYPE +: NTYPE]),
            .rx_spec_o (rx_spec[ch])
        );
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sio_src_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .as_rise (as_rise),
            .en      (src_en_i[s]),
            .cond    (cond[s]),
            .clr     (ip_clr_i[s]),
            .ip_o    (ip[s])
        );
    end

    sio_prio_arb #(.N(NSRC)) u_arb (
        .mie       (mie_i),
        .chain_in  (chain_in_i),
        .ip        (ip),
        .ius       (ius_q),
        .req_o     (req),
        .win_oh_o  (win_oh),
        .win_idx_o (win_idx)
    );

    // Pick the special flag of the channel that owns the winner.
    always_comb begin
        win_spec = (int'(win_idx) >= NTYPE) ? rx_spec[1] : rx_spec[0];
    end

    sio_vec_fmt #(.VEC_W(VEC_W), .STAT_LSB(STAT_LSB), .CODE_W(CODE_W)) u_vec (
        .base   (vec_base_i),
        .insert (stat_via_b_i),
        .code   (src_code(win_idx, win_spec)),
        .vec_o  (vec_next)
    );

    // Find the highest-priority under-service bit for the release command.
    always_comb begin
        ius_clr = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (ius_q[i]) begin
                ius_clr    = '0;
                ius_clr[i] = ius_reset_i;
            end
        end
    end

    assign ack_hit = intack_i & ds_fall & req;

    // Under-service bits: release by command, set by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ius_q <= '0;
        end else begin
            ius_q <= (ius_q & ~ius_clr) | (ack_hit ? win_oh : '0);
        end
    end

    // Capture and drive the vector for the length of the data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            oe_q  <= 1'b0;
        end else if (ack_hit) begin
            vec_q <= vec_next;
            oe_q  <= 1'b1;
        end else if (ds_n_i || !intack_i) begin
            oe_q  <= 1'b0;
        end
    end

    assign irq_n_o     = ~req;
    assign chain_out_o = chain_in_i & ~(|ius_q);
    assign vec_oe_o    = oe_q;
    assign vec_data_o  = vec_q;
    assign ip_o        = ip;
endmodule

// Assertion checker attached to the arbiter.
module sio_irq_checker
    import sio_irq_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int STAT_LSB = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ds_n_i,
    input logic             intack_i,
    input logic             chain_in_i,
    input logic             chain_out_o,
    input logic             irq_n_o,
    input logic             vec_oe_o,
    input logic [VEC_W-1:0] vec_data_o,
    input logic [VEC_W-1:0] vec_base_i,
    input logic             mie_i,
    input logic [NSRC-1:0]  src_en_i,
    input logic [NSRC-1:0]  ip_o,
    input logic [NSRC-1:0]  ius,
    input logic             ius_reset_i
);
    localparam logic [VEC_W-1:0] KEEP = ~(VEC_W'((1 << CODE_W) - 1) << STAT_LSB);

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        AST_EN_GATES_IP: assert property (@(posedge clk) disable iff (!rst_n)
            !src_en_i[i] |=> !ip_o[i]); // R2
    end

    AST_MIE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        !mie_i |-> irq_n_o); // R3

    AST_CHAIN_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_in_i |-> (irq_n_o && !chain_out_o)); // R4

    AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (|ip_o)); // R4

    AST_IUS_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (|ius) |-> !chain_out_o); // R5

    AST_ACK_TAKES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (intack_i && $fell(ds_n_i) && !irq_n_o && !ius_reset_i)
        |=> (vec_oe_o && ($countones(ius) > $countones($past(ius))))); // R7

    AST_VEC_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |-> (((vec_data_o ^ vec_base_i) & KEEP) == '0)); // R8
endmodule

bind sio_irq_arbiter sio_irq_checker #(.VEC_W(VEC_W), .STAT_LSB(STAT_LSB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ds_n_i      (ds_n_i),
    .intack_i    (intack_i),
    .chain_in_i  (chain_in_i),
    .chain_out_o (chain_out_o),
    .irq_n_o     (irq_n_o),
    .vec_oe_o    (vec_oe_o),
    .vec_data_o  (vec_data_o),
    .vec_base_i  (vec_base_i),
    .mie_i       (mie_i),
    .src_en_i    (src_en_i),
    .ip_o        (ip_o),
    .ius         (ius_q),
    .ius_reset_i (ius_reset_i)
);

// File: tb/tb_sio_irq_arbiter.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module tb_sio_irq_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_n = 1'b1, ds_n = 1'b1, intack = 1'b0, chain_in = 1'b1;
    logic chain_out, irq_n, vec_oe;
    logic [7:0] vec_data;
    logic mie = 1'b1;
    logic [5:0] src_en = 6'h3F;
    logic [3:0] rx_mode = 4'b0101;
    logic [1:0] par_spec = 2'b00;
    logic [7:0] vec_base = 8'hA5;
    logic via_b = 1'b0;
    logic [1:0] rx_char = 0, tx_load = 0, tx_empty = 0, ext_evt = 0;
    logic [7:0] rx_err = 0;
    logic [5:0] ip_clr = 0;
    logic ius_reset = 1'b0;
    logic [5:0] ip;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sio_irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .as_n_i(as_n), .ds_n_i(ds_n), .intack_i(intack),
        .chain_in_i(chain_in), .chain_out_o(chain_out), .irq_n_o(irq_n),
        .vec_oe_o(vec_oe), .vec_data_o(vec_data), .mie_i(mie), .src_en_i(src_en),
        .rx_mode_i(rx_mode), .par_spec_i(par_spec), .vec_base_i(vec_base),
        .stat_via_b_i(via_b), .rx_char_i(rx_char), .rx_err_i(rx_err),
        .tx_load_i(tx_load), .tx_empty_i(tx_empty), .ext_evt_i(ext_evt),
        .ip_clr_i(ip_clr), .ius_reset_i(ius_reset), .ip_o(ip)
    );

    // ---------------- reference model ----------------
    bit m_ip[6], m_ius[6];
    int m_cnt[6];
    bit m_first[2], m_arm[2], m_spec[2];
    bit m_asp, m_dsp, m_oe;
    logic [7:0] m_vec;
    int  w;
    bit  blk, hit, asr, cleared;
    bit  cnd[6];
    bit  spc[2], sph[2];

    function automatic int pick();
        int r = -1;
        bit b = 0;
        for (int i = 0; i < 6; i++) begin
            if (m_ius[i]) b = 1;
            if (r < 0 && !b && mie && m_ip[i]) r = i;
        end
        return r;
    endfunction

    function automatic logic [7:0] model_vec(int s, bit sp, bit vb);
        logic [7:0] v = vec_base;
        logic [2:0] c;
        case (s)
            0: c = sp ? 3'd7 : 3'd6;
            1: c = 3'd4;
            2: c = 3'd5;
            3: c = sp ? 3'd3 : 3'd2;
            4: c = 3'd0;
            default: c = 3'd1;
        endcase
        if (vb) v[3:1] = c;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin m_ip[i] = 0; m_ius[i] = 0; m_cnt[i] = -1; end
            for (int c = 0; c < 2; c++) begin m_first[c] = 0; m_arm[c] = 0; m_spec[c] = 0; end
            m_asp = 1; m_dsp = 1; m_oe = 0; m_vec = 0;
        end else begin
            w   = pick();
            hit = intack && !ds_n && m_dsp && chain_in && (w >= 0);
            asr = as_n && !m_asp;
            for (int c = 0; c < 2; c++) begin
                spc[c] = rx_err[4*c] | rx_err[4*c+1] | rx_err[4*c+2] | (rx_err[4*c+3] & par_spec[c]);
                case (rx_mode[2*c +: 2])
                    2'd0: begin sph[c] = spc[c] & m_first[c]; cnd[3*c] = (rx_char[c] & !m_first[c]) | sph[c]; end
                    2'd1: begin sph[c] = spc[c]; cnd[3*c] = rx_char[c] | spc[c]; end
                    default: begin sph[c] = spc[c]; cnd[3*c] = spc[c]; end
                endcase
                cnd[3*c] = cnd[3*c] & src_en[3*c];
                cnd[3*c+1] = tx_empty[c] & m_arm[c];
                cnd[3*c+2] = ext_evt[c];
            end
            if (hit) m_vec = model_vec(w, m_spec[w / 3], via_b);
            for (int c = 0; c < 2; c++) begin
                m_first[c] = src_en[3*c] && (m_first[c] || rx_char[c]);
                if (tx_load[c]) m_arm[c] = 1; else if (tx_empty[c]) m_arm[c] = 0;
                if (!src_en[3*c]) m_spec[c] = 0;
                else if (sph[c] && cnd[3*c]) m_spec[c] = 1;
                else if (ip_clr[3*c]) m_spec[c] = 0;
            end
            for (int i = 0; i < 6; i++) begin
                if (!src_en[i]) begin
                    m_cnt[i] = -1; m_ip[i] = 0;
                end else begin
                    if (ip_clr[i]) m_ip[i] = 0;
                    if (asr && m_cnt[i] >= 0) begin
                        m_cnt[i]++;
                        if (m_cnt[i] == 2) begin m_ip[i] = 1; m_cnt[i] = -1; end
                    end
                    if (cnd[i] && m_cnt[i] < 0) m_cnt[i] = 0;
                end
            end
            cleared = 0;
            if (ius_reset)
                for (int i = 0; i < 6; i++)
                    if (m_ius[i] && !cleared) begin m_ius[i] = 0; cleared = 1; end
            if (hit) begin m_ius[w] = 1; m_oe = 1; end
            else if (ds_n || !intack) m_oe = 0;
            m_asp = as_n; m_dsp = ds_n;
        end
    end

    function automatic bit m_irq_n();
        return !(chain_in && pick() >= 0);
    endfunction

    function automatic bit m_chain_out();
        bit any = 0;
        for (int i = 0; i < 6; i++) any |= m_ius[i];
        return chain_in && !any;
    endfunction

    function automatic logic [5:0] m_ipv();
        logic [5:0] v;
        for (int i = 0; i < 6; i++) v[i] = m_ip[i];
        return v;
    endfunction

    task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 irq_n vs model", {7'd0, irq_n}, {7'd0, m_irq_n()});
            chk("R5 chain_out vs model", {7'd0, chain_out}, {7'd0, m_chain_out()});
            chk("R6 ip vs model", {2'd0, ip}, {2'd0, m_ipv()});
            chk("R7 vec_oe vs model", {7'd0, vec_oe}, {7'd0, m_oe});
            if (m_oe) chk("R8 vector vs model", vec_data, m_vec);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic as_pulses(input int n);
        repeat (n) begin
            as_n = 0; cyc(2); as_n = 1; cyc(2);
        end
    endtask

    task automatic ack(input bit vb, output logic [7:0] v, output logic oe);
        via_b = vb; intack = 1; cyc(1);
        ds_n = 0; cyc(1);
        @(negedge clk); v = vec_data; oe = vec_oe;
        cyc(1); ds_n = 1; intack = 0; cyc(1);
    endtask

    task automatic release_src(input logic [5:0] m);
        ip_clr = m; ius_reset = 1; cyc(1); ip_clr = 0; ius_reset = 0; cyc(1);
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    logic [7:0] v;
    logic oe;

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        at_neg();
        chk("R4 reset irq_n", {7'd0, irq_n}, 8'd1);
        chk("R5 reset chain_out", {7'd0, chain_out}, 8'd1);
        chk("R6 reset ip", {2'd0, ip}, 8'd0);
        chk("R7 reset vec_oe", {7'd0, vec_oe}, 8'd0);

        // R6: two strobe ends needed
        cyc(1); ext_evt = 2'b10; cyc(1); ext_evt = 0;
        as_pulses(1); at_neg(); chk("R6 one edge not yet", {2'd0, ip}, 8'h00);
        cyc(1); as_pulses(1); at_neg(); chk("R6 pending after two edges", {2'd0, ip}, 8'h20);
        chk("R4 request active", {7'd0, irq_n}, 8'd0);

        // R1/R11/R8: A transmit outranks B external
        cyc(1); tx_load = 2'b01; cyc(1); tx_load = 0; tx_empty = 2'b01; cyc(1); tx_empty = 0;
        as_pulses(2); at_neg(); chk("R11 armed transmit pends", {2'd0, ip}, 8'h22);
        cyc(1); ack(1, v, oe);
        chk("R7 vector driven", {7'd0, oe}, 8'd1);
        chk("R1 R8 A-transmit code via B", v, 8'hA9);
        at_neg(); chk("R5 chain_out low under service", {7'd0, chain_out}, 8'd0);
        chk("R5 lower source blocked", {7'd0, irq_n}, 8'd1);
        cyc(1); release_src(6'h02);
        at_neg(); chk("R12 release reopens chain", {7'd0, chain_out}, 8'd1);
        cyc(1); ack(0, v, oe);
        chk("R8 vector via A unmodified", v, 8'hA5);
        cyc(1); release_src(6'h20);
        at_neg(); chk("R12 pending cleared", {2'd0, ip}, 8'h00);

        // R2: disabled source never pends
        cyc(1); src_en = 6'h3E; rx_char = 2'b01; cyc(1); rx_char = 0;
        as_pulses(2); at_neg(); chk("R2 disabled receive ignored", {2'd0, ip}, 8'h00);
        cyc(1); src_en = 6'h3F; cyc(1);

        // R3 and R4 gating
        ext_evt = 2'b01; cyc(1); ext_evt = 0; as_pulses(2);
        mie = 0; cyc(1); at_neg(); chk("R3 master off silences", {7'd0, irq_n}, 8'd1);
        cyc(1); mie = 1; chain_in = 0; cyc(1);
        at_neg(); chk("R4 chain_in low silences", {7'd0, irq_n}, 8'd1);
        cyc(1); ack(1, v, oe); chk("R4 no ack with chain_in low", {7'd0, oe}, 8'd0);
        chain_in = 1; ip_clr = 6'h04; cyc(1); ip_clr = 0; cyc(1);

        // R11: empty without load
        tx_empty = 2'b10; cyc(1); tx_empty = 0; as_pulses(2);
        at_neg(); chk("R11 unarmed transmit ignored", {2'd0, ip}, 8'h00);
        cyc(1); tx_load = 2'b10; cyc(1); tx_load = 0; tx_empty = 2'b10; cyc(1); tx_empty = 0;
        as_pulses(2); at_neg(); chk("R11 armed B transmit", {2'd0, ip}, 8'h10);
        cyc(1); ip_clr = 6'h10; cyc(1); ip_clr = 0;

        // R9/R10: first-character mode on A
        rx_mode = 4'b0100; cyc(1);
        rx_char = 2'b01; cyc(1); rx_char = 0; as_pulses(2);
        at_neg(); chk("R9 first character pends", {2'd0, ip}, 8'h01);
        cyc(1); ip_clr = 6'h01; cyc(1); ip_clr = 0;
        rx_char = 2'b01; cyc(1); rx_char = 0; as_pulses(2);
        at_neg(); chk("R9 second character ignored", {2'd0, ip}, 8'h00);
        cyc(1); rx_err = 8'h01; cyc(1); rx_err = 0; as_pulses(2);
        at_neg(); chk("R10 overrun pends", {2'd0, ip}, 8'h01);
        cyc(1); ack(1, v, oe); chk("R10 A special code", v, 8'hAF);
        release_src(6'h01);

        // R9/R10: special-only mode on B
        rx_mode = 4'b1000; cyc(1);
        rx_char = 2'b10; cyc(1); rx_char = 0; as_pulses(2);
        at_neg(); chk("R9 special-only ignores character", {2'd0, ip}, 8'h00);
        cyc(1); rx_err = 8'h80; cyc(1); rx_err = 0; as_pulses(2);
        at_neg(); chk("R10 parity not special by default", {2'd0, ip}, 8'h00);
        cyc(1); par_spec = 2'b10; rx_err = 8'h80; cyc(1); rx_err = 0; as_pulses(2);
        at_neg(); chk("R10 parity special when selected", {2'd0, ip}, 8'h08);
        cyc(1); ack(1, v, oe); chk("R10 B special code", v, 8'hA7);
        release_src(6'h08);

        // R12: nested service, release highest first
        ext_evt = 2'b10; cyc(1); ext_evt = 0; as_pulses(2);
        ack(1, v, oe); chk("R8 B external code", v, 8'hA3);
        ext_evt = 2'b01; cyc(1); ext_evt = 0; as_pulses(2);
        at_neg(); chk("R5 higher source not blocked", {7'd0, irq_n}, 8'd0);
        cyc(1); ack(1, v, oe); chk("R1 A external nested", v, 8'hAB);
        ius_reset = 1; cyc(1); ius_reset = 0; cyc(1);
        at_neg(); chk("R12 lower service still held", {7'd0, chain_out}, 8'd0);
        cyc(1); release_src(6'h24);
        at_neg(); chk("R12 all service released", {7'd0, chain_out}, 8'd1);

        cyc(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule